// File: doc/BRIEF.md
# Elitist Mutation Genetic Sequencer

This block drives an evolutionary search over configuration bit strings for a reconfigurable filter circuit. It keeps a population of POP chromosomes of CHROM_W bits (16 x 250 by default) in local storage, fills it from a bank of parallel 12-bit LFSR lanes, and then repeats a generation loop. Each member is offered to the external circuit. The circuit scores it over a full image and returns a score, where a lower value is better. After all members are scored, a sequential scan picks the winner. The next generation keeps the winner and fills the other slots with mutated copies of it.

The chromosome path is a valid/ready stream. `cand_valid` rises with `cand_data` and `cand_idx`, and both stay frozen until `cand_ready` is sampled high. The score path is a second valid/ready stream. `score_ready` is high only while the block waits for the score of the member it has just handed over, and `score_valid` has no effect at any other time. The sink may stall for any number of cycles on either path. `start` and `done` are plain level signals. `mut_thresh` sets the mutation rate and is meant to change only while the block is idle or done.

Top module: `ga_sequencer`

## Requirements
- R1: When `start` is accepted from idle or done, the block writes one random bit per cycle, member by member, bit 0 to CHROM_W-1. The first offer appears exactly POP*CHROM_W cycles after the `start` edge. Every initial member is non-zero and differs from every other member.
- R2: In every generation, members are offered in index order 0 to POP-1, and `cand_idx` shows the index of the member on `cand_data`.
- R3: While `cand_valid` is high and `cand_ready` is low, `cand_valid` stays high and `cand_data` stays stable. After an accepted offer, `cand_valid` is low and `score_ready` is high until a score is accepted.
- R4: The winner of a generation is the member with the lowest score. On equal scores, the lowest index wins.
- R5: In every generation after the first, member 0 is an unchanged copy of the previous winner.
- R6: Each offspring bit (members 1 to POP-1) is the winner's bit, inverted when the LFSR lane of that member, read as an unsigned number, is below `mut_thresh`. A `mut_thresh` of 0 gives exact copies. A `mut_thresh` of 4096 gives the bitwise complement. A `mut_thresh` of 2048 gives offspring that equal neither the winner nor its complement.
- R7: The first offer of a new generation appears exactly POP + 1 + (POP-1)*CHROM_W cycles after the edge that accepts the last score of the previous generation.
- R8: After GENS scored generations, `done` rises exactly POP + 1 cycles after the last score is accepted. `cand_data` then holds the final winner and `cand_valid` stays low. `cand_ready` and `score_valid` have no effect while the block is done.
- R9: A `start` while the block is done clears `done` in the next cycle and begins a new run from a fresh random population.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| mut_thresh | input | LFSR_W+1 | Flip threshold compared with a lane value |
| done | output | 1 | Run finished, winner held on `cand_data` |
| cand_valid | output | 1 | A chromosome is offered |
| cand_ready | input | 1 | Sink accepts the offered chromosome |
| cand_idx | output | $clog2(POP) | Population index of the offer |
| cand_data | output | CHROM_W | Offered chromosome, or the final winner when done |
| score_valid | input | 1 | Score on `score_data` is valid |
| score_ready | output | 1 | Block waits for a score |
| score_data | input | SCORE_W | Score, lower is better |

## Verification
Scores are drawn at random, with forced patterns added. One pattern is a two-way tie for the minimum, which separates a strict comparison from a non-strict one. Another puts the lowest score at the last index, which catches a scan that stops one member early. Mutation is tried at three thresholds. A zero threshold must give exact copies, a full threshold must give exact complements, and a half threshold must give something in between, which shows that flips depend on the lane value and not on a constant. Random stalls on both streams test the hold rules. The exact cycle counts of the fill, breed and select phases are measured, so any miscounted loop bound shows up in the result.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_OFFER,
    S_WAIT,
    S_SCAN,
    S_ELITE,
    S_MUTATE,
    S_DONE
  } ga_state_e;
endpackage

// File: rtl/ga_lfsr_bank.sv
module ga_lfsr_bank #(
  parameter int LANES = 16,
  parameter int W = 12,
  parameter logic [W-1:0] TAPS = 'h829
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [LANES-1:0][W-1:0]  lanes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= W'(g * 37 + 1);
      else        st <= {1'b0, st[W-1:1]} ^ (st[0] ? TAPS : '0);
    end
    assign lanes[g] = st;

    AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0); // R1
  end
endmodule

// File: rtl/ga_best_scan.sv
module ga_best_scan #(
  parameter int N = 16,
  parameter int SCORE_W = 24,
  localparam int IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               first,
  input  logic [IW-1:0]      idx,
  input  logic [SCORE_W-1:0] score,
  output logic [IW-1:0]      best_idx,
  output logic [SCORE_W-1:0] best_score
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_idx   <= '0;
      best_score <= '0;
    end else if (step) begin
      if (first || score < best_score) begin
        best_idx   <= idx;
        best_score <= score;
      end
    end
  end

  AST_BEST_NOT_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !first |=> best_score <= $past(best_score)); // R4
endmodule

// File: rtl/ga_sequencer.sv
module ga_sequencer
  import ga_pkg::*;
#(
  parameter int POP = 16,
  parameter int CHROM_W = 250,
  parameter int SCORE_W = 24,
  parameter int LFSR_W = 12,
  parameter int GENS = 3000,
  localparam int POP_W = $clog2(POP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LFSR_W:0]    mut_thresh,
  output logic               done,
  output logic               cand_valid,
  input  logic               cand_ready,
  output logic [POP_W-1:0]   cand_idx,
  output logic [CHROM_W-1:0] cand_data,
  input  logic               score_valid,
  output logic               score_ready,
  input  logic [SCORE_W-1:0] score_data
);
  localparam int BIT_W = $clog2(CHROM_W);
  localparam int GEN_W = $clog2(GENS + 1);

  ga_state_e state;
  logic [POP_W-1:0] mem;
  logic [BIT_W-1:0] bitp;
  logic [GEN_W-1:0] gen;
  logic [CHROM_W-1:0] pop [POP];
  logic [CHROM_W-1:0] elite;
  logic [SCORE_W-1:0] score_mem [POP];
  logic [POP-1:0][LFSR_W-1:0] lanes;
  logic [POP_W-1:0] best_idx;
  logic [SCORE_W-1:0] best_score;
  logic scan_step, scan_first, last_bit, last_mem, flip;

  ga_lfsr_bank #(.LANES(POP), .W(LFSR_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .lanes(lanes)
  );

  assign scan_step  = (state == S_SCAN);
  assign scan_first = (mem == '0);

  ga_best_scan #(.N(POP), .SCORE_W(SCORE_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .step(scan_step), .first(scan_first),
    .idx(mem), .score(score_mem[mem]),
    .best_idx(best_idx), .best_score(best_score)
  );

  assign last_bit = (bitp == BIT_W'(CHROM_W - 1));
  assign last_mem = (mem == POP_W'(POP - 1));
  assign flip     = ({1'b0, lanes[mem]} < mut_thresh);

  assign done        = (state == S_DONE);
  assign cand_valid  = (state == S_OFFER);
  assign score_ready = (state == S_WAIT);
  assign cand_idx    = mem;
  assign cand_data   = (state == S_DONE) ? elite : pop[mem];

  // population and score storage, no reset needed
  always_ff @(posedge clk) begin
    if (state == S_FILL) begin
      pop[mem][bitp] <= lanes[mem][0];
    end else if (state == S_MUTATE) begin
      pop[0]         <= elite;
      pop[mem][bitp] <= elite[bitp] ^ flip;
    end
    if (state == S_WAIT && score_valid) score_mem[mem] <= score_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mem   <= '0;
      bitp  <= '0;
      gen   <= '0;
      elite <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            state <= S_FILL;
            mem   <= '0;
            bitp  <= '0;
            gen   <= '0;
          end
        end
        S_FILL, S_MUTATE: begin
          if (last_bit) begin
            bitp <= '0;
            if (last_mem) begin
              mem   <= '0;
              state <= S_OFFER;
            end else begin
              mem <= mem + 1'b1;
            end
          end else begin
            bitp <= bitp + 1'b1;
          end
        end
        S_OFFER: begin
          if (cand_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (score_valid) begin
            if (last_mem) begin
              mem   <= '0;
              state <= S_SCAN;
            end else begin
              mem   <= mem + 1'b1;
              state <= S_OFFER;
            end
          end
        end
        S_SCAN: begin
          if (last_mem) state <= S_ELITE;
          else          mem   <= mem + 1'b1;
        end
        S_ELITE: begin
          elite <= pop[best_idx];
          gen   <= gen + 1'b1;
          if (gen + 1'b1 == GEN_W'(GENS)) begin
            state <= S_DONE;
          end else begin
            state <= S_MUTATE;
            mem   <= POP_W'(1);
            bitp  <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_data) && $stable(cand_idx)); // R3
  AST_SCORE_AFTER_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(score_ready) |-> $past(cand_valid && cand_ready)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid && !score_ready); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cand_data)); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done); // R9
endmodule

// File: tb/ga_sequencer_bench.sv
module ga_sequencer_bench;
  localparam int POP = 16;
  localparam int CH = 250;
  localparam int SW = 24;
  localparam int LW = 12;
  localparam int GENS = 3;
  localparam int FILL_CYC = POP * CH;
  localparam int BREED_CYC = POP + 1 + (POP - 1) * CH;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [LW:0] mut_thresh = '0;
  logic done, cand_valid, score_ready;
  logic cand_ready = 0;
  logic score_valid = 0;
  logic [SW-1:0] score_data = '0;
  logic [3:0] cand_idx;
  logic [CH-1:0] cand_data;

  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ga_sequencer #(.POP(POP), .CHROM_W(CH), .SCORE_W(SW), .LFSR_W(LW), .GENS(GENS)) u_ga_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .mut_thresh(mut_thresh), .done(done),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_idx(cand_idx),
    .cand_data(cand_data), .score_valid(score_valid), .score_ready(score_ready),
    .score_data(score_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    while (!cand_valid) @(negedge clk);
  endtask

  // mode: 0 fresh fill, 1 copies, 2 complements, 3 partial flips
  // tie: 0 random, 1 tie at members 3 and 9, 2 minimum at the last member
  task automatic run_round(input int mode, input int tie, input logic [CH-1:0] prev,
                           input int unsigned prev_w, output logic [CH-1:0] best,
                           output int unsigned w_out);
    logic [CH-1:0] got [POP];
    int sc [POP];
    int bi;
    for (int m = 0; m < POP; m++) sc[m] = $urandom_range(50, 2000);
    if (tie == 1) begin sc[3] = 7; sc[9] = 7; end
    if (tie == 2) sc[POP-1] = 1;
    for (int m = 0; m < POP; m++) begin
      wait_valid();
      if (m == 0 && prev_w != 0)
        chk(cyc - prev_w == BREED_CYC, "R7 breed latency", 256'(cyc - prev_w), 256'(BREED_CYC));
      chk(cand_idx == 4'(m), "R2 offer order", 256'(cand_idx), 256'(m));
      got[m] = cand_data;
      for (int h = $urandom_range(0, 2); h > 0; h--) begin
        @(negedge clk);
        chk(cand_valid && cand_data == got[m], "R3 hold under stall", 256'(cand_data), 256'(got[m]));
      end
      cand_ready = 1;
      @(negedge clk);
      cand_ready = 0;
      chk(!cand_valid && score_ready, "R3 wait for score", {254'd0, cand_valid, score_ready}, 256'd1);
      for (int h = $urandom_range(0, 2); h > 0; h--) @(negedge clk);
      score_valid = 1;
      score_data = SW'(sc[m]);
      @(negedge clk);
      score_valid = 0;
      w_out = cyc;
    end
    bi = 0;
    for (int m = 1; m < POP; m++) if (sc[m] < sc[bi]) bi = m;
    best = got[bi];
    for (int m = 0; m < POP; m++) begin
      if (mode == 0) begin
        chk(got[m] != '0, "R1 nonzero fill", 256'(got[m]), 256'd1);
        for (int k = 0; k < m; k++)
          if (got[k] == got[m]) chk(0, "R1 distinct fill", 256'(k), 256'(m));
      end else if (m == 0) begin
        chk(got[0] == prev, "R5 elite kept", 256'(got[0]), 256'(prev));
      end else if (mode == 1) begin
        chk(got[m] == prev, "R6 zero threshold", 256'(got[m]), 256'(prev));
      end else if (mode == 2) begin
        chk(got[m] == ~prev, "R6 full threshold", 256'(got[m]), 256'(~prev));
      end else begin
        chk(got[m] != prev && got[m] != ~prev, "R6 partial threshold", 256'(got[m]), 256'(prev));
      end
    end
  endtask

  task automatic full_run(input logic [LW:0] th, input int tie_first, input int tie_last);
    int unsigned t0, w;
    logic [CH-1:0] best, prev;
    mut_thresh = th;
    start = 1;
    @(negedge clk);
    start = 0;
    t0 = cyc;
    chk(!done, "R9 done cleared by start", 256'(done), 256'd0);
    wait_valid();
    chk(cyc - t0 == FILL_CYC, "R1 fill latency", 256'(cyc - t0), 256'(FILL_CYC));
    run_round(0, tie_first, '0, 0, best, w);
    for (int g = 1; g < GENS; g++) begin
      prev = best;
      run_round(th == 0 ? 1 : (th == 13'd4096 ? 2 : 3), (g == GENS - 1) ? tie_last : 0,
                prev, w, best, w);
    end
    while (!done) @(negedge clk);
    chk(cyc - w == POP + 1, "R8 done latency", 256'(cyc - w), 256'(POP + 1));
    chk(cand_data == best, "R4 lowest score earliest index", 256'(cand_data), 256'(best));
    chk(!cand_valid && !score_ready, "R8 quiet when done", {254'd0, cand_valid, score_ready}, 256'd0);
    cand_ready = 1;
    score_valid = 1;
    score_data = '0;
    repeat (3) @(negedge clk);
    cand_ready = 0;
    score_valid = 0;
    @(negedge clk);
    chk(done && cand_data == best && !cand_valid, "R8 inputs ignored when done", 256'(cand_data), 256'(best));
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(!done && !cand_valid && !score_ready, "R3 reset state",
        {253'd0, done, cand_valid, score_ready}, 256'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !cand_valid, "R1 idle after reset", {254'd0, done, cand_valid}, 256'd0);
    full_run(13'd0, 1, 2);
    full_run(13'd4096, 0, 1);
    full_run(13'd2048, 2, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule